// File: doc/BRIEF.md
# Multi-Mode Compare Timer Waveform Generator

This block is a timer/counter with a set of compare channels, each driving one waveform output. A three-bit mode input selects one of seven waveform schemes. Two are frequency schemes where an output toggles on each compare match. One is single-slope PWM. Four are dual-slope PWM variants that differ only in where the overflow flag and event are raised. A count-enable tick advances the counter. The period and compare values are written into shadow buffers and only take effect at the update point that the selected mode defines. This keeps a running waveform free of glitches while software changes it.

Each channel has a sticky match flag. The counter has a sticky overflow flag and a one-cycle overflow event pulse. Each output passes through its own inversion control after generation. In match-frequency mode, compare value 0 sets the counter's TOP. In every other mode, the period register sets TOP.

Top module: `wavegen_timer`

## Requirements
- R1: `mode_i` encoding is 0 = normal frequency, 1 = match frequency, 2 = single-slope PWM, 4 = dual-slope critical (overflow at ZERO), 5 = dual-slope overflow at ZERO, 6 = dual-slope overflow at TOP and ZERO, 7 = dual-slope overflow at TOP. Code 3 is reserved and behaves as normal frequency.
- R2: In match-frequency mode TOP is the active compare value of channel 0. In every other mode TOP is the active period value.
- R3: In single-slope modes (0–3), each tick counts up and moves from any value at or above TOP to 0, or counts down when `cnt_down_i`=1 and moves from 0 to TOP. Without a tick the count holds.
- R4: In dual-slope modes (4–7), the counter runs 0 up to TOP, then down to 0, and reverses at each end without repeating the end value.
- R5: A channel's match flag is set on a tick taken while the count equals that channel's active compare value. It stays set until `match_clr_i` for that channel is high for a cycle. A new set wins over a clear in the same cycle.
- R6: In frequency modes (0, 1, 3), the raw channel output toggles on each matching tick. A buffer update does not change it. The raw output resets to 0.
- R7: In PWM modes (2, 4–7), the raw channel output is 1 while the count is below the active compare value and 0 otherwise.
- R8: In single-slope modes, overflow is raised on the wrapping tick: at TOP when counting up, at ZERO when counting down.
- R9: In dual-slope modes, overflow is raised at the ZERO turn for modes 4 and 5, at the TOP turn for mode 7, and at both turns for mode 6.
- R10: The overflow flag is set on an overflowing tick. It stays set until `ovf_clr_i` (a set wins over a clear). `ovf_evt_o` is high for exactly the cycle after each overflowing tick.
- R11: Period and compare writes go into shadow buffers. A pending buffer is copied to the active value at the update point, and a write in the same cycle stays pending. Single-slope modes update on the wrapping tick. Dual-slope modes update on the ZERO turn.
- R12: In mode 6, a channel with `circ_en_i` set also copies its pending compare value at the TOP turn. The period copies only at ZERO.
- R13: `wave_o[i]` is the raw channel output XOR `inv_i[i]`.
- R14: Reset sets count 0, counting up, period all ones, all compare values 0, no pending buffers, and all flags, events and raw outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Waveform mode select |
| cnt_down_i | input | 1 | Count direction for single-slope modes (1 = down) |
| tick_i | input | 1 | Count enable |
| per_wdata_i | input | CW | Period buffer write data |
| per_wr_i | input | 1 | Period buffer write strobe |
| cc_wdata_i | input | CW | Compare buffer write data |
| cc_wr_i | input | NCH | Per-channel compare buffer write strobes |
| circ_en_i | input | NCH | Per-channel extra update at TOP in mode 6 |
| inv_i | input | NCH | Per-output inversion |
| match_clr_i | input | NCH | Per-channel match flag clear |
| ovf_clr_i | input | 1 | Overflow flag clear |
| count_o | output | CW | Current count |
| match_flag_o | output | NCH | Sticky match flags |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ovf_evt_o | output | 1 | One-cycle overflow event |
| wave_o | output | NCH | Waveform outputs |

## Verification
The bench targets the turn points of the dual-slope counter. A design that repeats the end value, or flags overflow at the wrong turn for a given variant, shows a count or event mismatch within one period. It also targets buffer writes that land on the update tick itself. A design that lets such a write through at once changes TOP or the duty cycle a full period early. Match-frequency runs move TOP along with compare 0. Mode 6 runs with circular buffering enabled, where a design that ignores the TOP update keeps the old duty cycle for half a period. Compare values at, above and at zero relative to TOP cover outputs that stay fixed and match flags that never fire.

// File: rtl/wg_pkg.sv
package wg_pkg;

  typedef enum logic [2:0] {
    WG_FREQ      = 3'd0,
    WG_MATCHFREQ = 3'd1,
    WG_PWM1      = 3'd2,
    WG_RSVD      = 3'd3,
    WG_DS_CRIT   = 3'd4,
    WG_DS_LOW    = 3'd5,
    WG_DS_BOTH   = 3'd6,
    WG_DS_HIGH   = 3'd7
  } wg_mode_e;

  // dual-slope family occupies the upper half of the code space
  function automatic logic mode_is_dual(input wg_mode_e m);
    return m[2];
  endfunction

  // toggle-on-match family (reserved code falls back to normal frequency)
  function automatic logic mode_is_freq(input wg_mode_e m);
    return (m == WG_FREQ) || (m == WG_MATCHFREQ) || (m == WG_RSVD);
  endfunction

  function automatic logic ovf_on_top(input wg_mode_e m);
    return (m == WG_DS_HIGH) || (m == WG_DS_BOTH);
  endfunction

  function automatic logic ovf_on_zero(input wg_mode_e m);
    return (m == WG_DS_CRIT) || (m == WG_DS_LOW) || (m == WG_DS_BOTH);
  endfunction

endpackage

// File: rtl/wg_shadow.sv
module wg_shadow #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         upd,
  output logic [W-1:0] act
);
  logic [W-1:0] buf_q;
  logic         pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= RST_VAL;
      buf_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (upd && pend_q) begin
        act <= buf_q;
      end
      if (wr) begin
        buf_q  <= wdata;
        pend_q <= 1'b1;
      end else if (upd) begin
        pend_q <= 1'b0;
      end
    end
  end

  assert_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && pend_q) |=> (act == $past(buf_q)));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd) |=> $stable(act));

endmodule

// File: rtl/wg_counter.sv
module wg_counter
  import wg_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cnt_down,
  input  wg_mode_e      mode,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] count,
  output logic          falling,
  output logic          top_hit,
  output logic          zero_hit
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic          dual;
  logic          at_top;
  logic          at_zero;
  logic [CW-1:0] cnt_nxt;
  logic          fall_nxt;

  assign dual    = mode_is_dual(mode);
  assign at_top  = (count >= top);
  assign at_zero = (count == '0);

  always_comb begin
    top_hit  = 1'b0;
    zero_hit = 1'b0;
    cnt_nxt  = count;
    fall_nxt = falling;
    if (tick) begin
      if (dual) begin
        if (!falling) begin
          if (at_top) begin
            top_hit  = 1'b1;
            fall_nxt = 1'b1;
            cnt_nxt  = at_zero ? '0 : count - ONE;
          end else begin
            cnt_nxt = count + ONE;
          end
        end else begin
          if (at_zero) begin
            zero_hit = 1'b1;
            fall_nxt = 1'b0;
            cnt_nxt  = (top == '0) ? '0 : ONE;
          end else begin
            cnt_nxt = count - ONE;
          end
        end
      end else if (!cnt_down) begin
        if (at_top) begin
          top_hit = 1'b1;
          cnt_nxt = '0;
        end else begin
          cnt_nxt = count + ONE;
        end
      end else begin
        if (at_zero) begin
          zero_hit = 1'b1;
          cnt_nxt  = top;
        end else begin
          cnt_nxt = count - ONE;
        end
      end
    end
    if (!dual) begin
      fall_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      falling <= 1'b0;
    end else begin
      count   <= cnt_nxt;
      falling <= fall_nxt;
    end
  end

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick) |=> $stable(count));

  assert_turn_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (top_hit && dual) |=> falling);

  assert_turn_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_hit && dual) |=> !falling);

  assert_one_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(top_hit && zero_hit));

endmodule

// File: rtl/wg_overflow.sv
module wg_overflow
  import wg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wg_mode_e mode,
  input  logic     top_hit,
  input  logic     zero_hit,
  input  logic     clr,
  output logic     flag,
  output logic     evt
);
  logic ovf_now;

  always_comb begin
    if (mode_is_dual(mode)) begin
      ovf_now = (top_hit && ovf_on_top(mode)) || (zero_hit && ovf_on_zero(mode));
    end else begin
      ovf_now = top_hit || zero_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      evt  <= 1'b0;
    end else begin
      evt <= ovf_now;
      if (ovf_now) begin
        flag <= 1'b1;
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end

  assert_evt_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> flag);

  assert_single_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_is_dual(mode) && (top_hit || zero_hit)) |=> evt);

  assert_ds_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == WG_DS_HIGH) && zero_hit) |=> !evt);

endmodule

// File: rtl/wg_channel.sv
module wg_channel
  import wg_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  wg_mode_e      mode,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] cc,
  input  logic          inv,
  input  logic          mclr,
  output logic          match_flag,
  output logic          wave
);
  logic match_tick;
  logic tog_q;
  logic raw;

  function automatic logic pwm_level(input logic [CW-1:0] c, input logic [CW-1:0] thr);
    return c < thr;
  endfunction

  assign match_tick = tick && (count == cc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q      <= 1'b0;
      match_flag <= 1'b0;
    end else begin
      if (match_tick && mode_is_freq(mode)) begin
        tog_q <= ~tog_q;
      end
      if (match_tick) begin
        match_flag <= 1'b1;
      end else if (mclr) begin
        match_flag <= 1'b0;
      end
    end
  end

  assign raw  = mode_is_freq(mode) ? tog_q : pwm_level(count, cc);
  assign wave = raw ^ inv;

  assert_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_tick |=> match_flag);

  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_tick && mode_is_freq(mode)) |=> (tog_q != $past(tog_q)));

  assert_no_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_tick) |=> $stable(tog_q));

endmodule

// File: rtl/wavegen_timer.sv
module wavegen_timer
  import wg_pkg::*;
#(
  parameter int CW  = 8,
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     mode_i,
  input  logic           cnt_down_i,
  input  logic           tick_i,
  input  logic [CW-1:0]  per_wdata_i,
  input  logic           per_wr_i,
  input  logic [CW-1:0]  cc_wdata_i,
  input  logic [NCH-1:0] cc_wr_i,
  input  logic [NCH-1:0] circ_en_i,
  input  logic [NCH-1:0] inv_i,
  input  logic [NCH-1:0] match_clr_i,
  input  logic           ovf_clr_i,
  output logic [CW-1:0]  count_o,
  output logic [NCH-1:0] match_flag_o,
  output logic           ovf_flag_o,
  output logic           ovf_evt_o,
  output logic [NCH-1:0] wave_o
);
  localparam logic [CW-1:0] PER_RST = {CW{1'b1}};

  wg_mode_e      mode;
  logic [CW-1:0] per_act;
  logic [CW-1:0] cc_act [NCH];
  logic [CW-1:0] top;
  logic          falling;
  logic          top_hit;
  logic          zero_hit;
  logic          upd_all;
  logic [NCH-1:0] upd_ch;

  assign mode = wg_mode_e'(mode_i);
  assign top  = (mode == WG_MATCHFREQ) ? cc_act[0] : per_act;

  // update point: ZERO turn for dual-slope, any wrap otherwise
  assign upd_all = mode_is_dual(mode) ? zero_hit : (top_hit || zero_hit);

  wg_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .cnt_down (cnt_down_i),
    .mode     (mode),
    .top      (top),
    .count    (count_o),
    .falling  (falling),
    .top_hit  (top_hit),
    .zero_hit (zero_hit)
  );

  wg_shadow #(.W(CW), .RST_VAL(PER_RST)) u_per (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (per_wr_i),
    .wdata (per_wdata_i),
    .upd   (upd_all),
    .act   (per_act)
  );

  wg_overflow u_ovf (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .top_hit  (top_hit),
    .zero_hit (zero_hit),
    .clr      (ovf_clr_i),
    .flag     (ovf_flag_o),
    .evt      (ovf_evt_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign upd_ch[i] = upd_all || ((mode == WG_DS_BOTH) && top_hit && circ_en_i[i]);

    wg_shadow #(.W(CW), .RST_VAL('0)) u_cc (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cc_wr_i[i]),
      .wdata (cc_wdata_i),
      .upd   (upd_ch[i]),
      .act   (cc_act[i])
    );

    wg_channel #(.CW(CW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_i),
      .mode       (mode),
      .count      (count_o),
      .cc         (cc_act[i]),
      .inv        (inv_i[i]),
      .mclr       (match_clr_i[i]),
      .match_flag (match_flag_o[i]),
      .wave       (wave_o[i])
    );
  end

  assert_period_at_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_is_dual(mode) && !zero_hit) |=> $stable(per_act));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_is_dual(mode) && !top_hit && !zero_hit) |=> !ovf_evt_o);

endmodule

// File: tb/tb_wavegen_timer.sv
module tb_wavegen_timer;
  localparam int CW  = 8;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2:0]     mode_i = 3'd0;
  logic           cnt_down_i = 1'b0;
  logic           tick_i = 1'b0;
  logic [CW-1:0]  per_wdata_i = '0;
  logic           per_wr_i = 1'b0;
  logic [CW-1:0]  cc_wdata_i = '0;
  logic [NCH-1:0] cc_wr_i = '0;
  logic [NCH-1:0] circ_en_i = '0;
  logic [NCH-1:0] inv_i = '0;
  logic [NCH-1:0] match_clr_i = '0;
  logic           ovf_clr_i = 1'b0;
  logic [CW-1:0]  count_o;
  logic [NCH-1:0] match_flag_o;
  logic           ovf_flag_o;
  logic           ovf_evt_o;
  logic [NCH-1:0] wave_o;

  always #4 clk = ~clk;

  wavegen_timer #(.CW(CW), .NCH(NCH)) dut (.*);

  int unsigned checks = 0;
  int unsigned fails  = 0;
  bit          done   = 1'b0;

  // bench reference state
  logic [CW-1:0] m_cnt, m_per, m_perb;
  bit            m_fall, m_perv, m_of, m_ev;
  logic [CW-1:0] m_cc [NCH];
  logic [CW-1:0] m_ccb [NCH];
  bit            m_ccv [NCH];
  bit            m_tog [NCH];
  bit            m_mf  [NCH];
  int            m_upd;
  int            tgt_per;

  function automatic bit b_dual(input logic [2:0] m);
    return m >= 3'd4;
  endfunction
  function automatic bit b_freq(input logic [2:0] m);
    return m <= 3'd3 && m != 3'd2;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_fall = 0; m_per = '1; m_perb = '0; m_perv = 0;
    m_of = 0; m_ev = 0; m_upd = 0;
    for (int i = 0; i < NCH; i++) begin
      m_cc[i] = '0; m_ccb[i] = '0; m_ccv[i] = 0; m_tog[i] = 0; m_mf[i] = 0;
    end
  endtask

  task automatic model_step();
    logic [CW-1:0] top, nc;
    bit th, zh, ovf, upd;
    bit mt [NCH];
    top = (mode_i == 3'd1) ? m_cc[0] : m_per;
    th = 0; zh = 0; nc = m_cnt;
    for (int i = 0; i < NCH; i++) mt[i] = tick_i && (m_cnt == m_cc[i]);
    if (tick_i) begin
      if (b_dual(mode_i)) begin
        if (!m_fall) begin
          if (m_cnt >= top) begin th = 1; m_fall = 1; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
          else nc = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin zh = 1; m_fall = 0; nc = (top == 0) ? 0 : 1; end
          else nc = m_cnt - 1;
        end
      end else if (!cnt_down_i) begin
        if (m_cnt >= top) begin th = 1; nc = 0; end else nc = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin zh = 1; nc = top; end else nc = m_cnt - 1;
      end
    end
    if (!b_dual(mode_i)) m_fall = 0;
    m_cnt = nc;
    case (mode_i)
      3'd4, 3'd5: ovf = zh;
      3'd6:       ovf = th | zh;
      3'd7:       ovf = th;
      default:    ovf = th | zh;
    endcase
    m_ev = ovf;
    if (ovf) m_of = 1; else if (ovf_clr_i) m_of = 0;
    upd = b_dual(mode_i) ? zh : (th | zh);
    m_upd = 0;
    if (upd && m_perv) begin m_per = m_perb; m_upd = 1; end
    if (per_wr_i) begin m_perb = per_wdata_i; m_perv = 1; end else if (upd) m_perv = 0;
    for (int i = 0; i < NCH; i++) begin
      bit u;
      u = upd || (mode_i == 3'd6 && th && circ_en_i[i]);
      if (u && m_ccv[i]) begin
        m_cc[i] = m_ccb[i];
        if (m_upd == 0) m_upd = (upd ? 1 : 2);
      end
      if (cc_wr_i[i]) begin m_ccb[i] = cc_wdata_i; m_ccv[i] = 1; end else if (u) m_ccv[i] = 0;
      if (mt[i] && b_freq(mode_i)) m_tog[i] = ~m_tog[i];
      if (mt[i]) m_mf[i] = 1; else if (match_clr_i[i]) m_mf[i] = 0;
    end
  endtask

  task automatic check_outputs();
    string tc, to, tw;
    logic [NCH-1:0] ew;
    tc = (mode_i == 3'd3) ? "R1" : (mode_i == 3'd1) ? "R2" : b_dual(mode_i) ? "R4" : "R3";
    to = (mode_i == 3'd3) ? "R1" : b_dual(mode_i) ? "R9" : "R8";
    tw = (m_upd == 2) ? "R12" : (m_upd == 1) ? "R11" : (inv_i != 0) ? "R13" :
         b_freq(mode_i) ? "R6" : "R7";
    for (int i = 0; i < NCH; i++)
      ew[i] = (b_freq(mode_i) ? m_tog[i] : (m_cnt < m_cc[i])) ^ inv_i[i];
    chk(tc, 32'(count_o), 32'(m_cnt), "count");
    chk(to, 32'(ovf_flag_o), 32'(m_of), "overflow flag");
    chk("R10", 32'(ovf_evt_o), 32'(m_ev), "overflow event");
    for (int i = 0; i < NCH; i++)
      chk("R5", 32'(match_flag_o[i]), 32'(m_mf[i]), $sformatf("match flag %0d", i));
    chk(tw, 32'(wave_o), 32'(ew), "waveform");
  endtask

  task automatic drive_random(input int cyc);
    tick_i      = ($urandom_range(99) < 80);
    per_wr_i    = 1'b0;
    cc_wr_i     = '0;
    match_clr_i = '0;
    ovf_clr_i   = 1'b0;
    if (cyc < NCH) begin
      cc_wr_i[cyc] = 1'b1;
      cc_wdata_i   = CW'($urandom_range(tgt_per + 2));
      if (cyc == 0) begin per_wr_i = 1'b1; per_wdata_i = CW'(tgt_per); end
    end else begin
      if ($urandom_range(99) < 4) begin
        tgt_per = $urandom_range(12, 3);
        per_wr_i = 1'b1; per_wdata_i = CW'(tgt_per);
      end
      if ($urandom_range(99) < 10) begin
        cc_wr_i[$urandom_range(NCH-1)] = 1'b1;
        cc_wdata_i = CW'($urandom_range(tgt_per + 2));
      end
      if ($urandom_range(99) < 10) match_clr_i = NCH'($urandom);
      if ($urandom_range(99) < 10) ovf_clr_i = 1'b1;
      if ($urandom_range(99) < 3)  inv_i = NCH'($urandom);
      if ($urandom_range(99) < 2)  cnt_down_i = ~cnt_down_i;
      if ($urandom_range(99) < 5)  circ_en_i = NCH'($urandom);
    end
  endtask

  task automatic run_phase(input logic [2:0] m, input int ncyc);
    @(negedge clk);
    rst_n = 1'b0;
    mode_i = m; tick_i = 0; per_wr_i = 0; cc_wr_i = '0;
    match_clr_i = '0; ovf_clr_i = 0; inv_i = '0; cnt_down_i = 0;
    circ_en_i = (m == 3'd6) ? '1 : '0;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    // R14: reset state observed at the ports
    chk("R14", 32'(count_o), 0, "reset count");
    chk("R14", 32'({match_flag_o, ovf_flag_o, ovf_evt_o}), 0, "reset flags");
    chk("R14", 32'(wave_o), 0, "reset waveform");
    tgt_per = $urandom_range(12, 3);
    for (int c = 0; c < ncyc; c++) begin
      if (c > 0) begin
        @(negedge clk);
        check_outputs();
      end
      drive_random(c);
      model_step();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_phase(3'd0, 1500);
    run_phase(3'd1, 1500);
    run_phase(3'd2, 1500);
    run_phase(3'd4, 1500);
    run_phase(3'd5, 1500);
    run_phase(3'd6, 1500);
    run_phase(3'd7, 1500);
    run_phase(3'd3, 1500);   // R1 reserved code acts as normal frequency
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule